// File: doc/BRIEF.md
# Clock-to-Signal Edge Delay Meter

This block watches two sampled 1-bit channels, a reference clock channel and a dependent signal channel, and measures how many sample ticks pass from a qualifying reference edge to the next qualifying dependent edge. A sample is taken on every system clock cycle in which the sample strobe is high. Each channel has its own selector that picks which transitions qualify. The measured delay is reported as a tick count with a one-cycle valid pulse.

The matcher alternates between waiting for a reference edge and waiting for a dependent edge. An edge that arrives out of turn does not restart the measurement. It is counted as a miss on its own wrapping counter, and a one-cycle pulse marks each increment. A reference edge and a dependent edge in the same sample give a delay of zero. When both edges arrive while a measurement is open, that measurement is closed and a new one opens at the same sample.

Top module: `edge_delay_meter`

## Requirements
- R1: After reset the block waits for a reference edge. The stored previous samples of both channels are 0. Both miss counters, both miss pulses, `delay_valid_o` and `delay_o` are 0.
- R2: The edge selector of each channel uses these codes: 2'b00 means rising only (previous 0, current 1), 2'b01 means falling only (previous 1, current 0), and 2'b10 or 2'b11 means any change.
- R3: A cycle with `smp_en_i` low is ignored. It does not update the stored previous samples, it does not advance the tick count, and it produces no pulse.
- R4: While waiting for a reference edge, a qualifying reference edge opens a measurement. The next qualifying dependent edge closes it. The cycle after the closing sample, `delay_valid_o` pulses for one cycle and `delay_o` holds the number of enabled samples from the opening sample to the closing sample. `delay_o` holds its value until the next pulse.
- R5: If a qualifying reference edge and a qualifying dependent edge fall on the same sample while waiting for a reference edge, a delay of 0 is reported and the block keeps waiting for a reference edge.
- R6: A qualifying reference edge seen while a measurement is open, with no dependent edge in the same sample, increments the reference-miss counter. The opening point of the measurement is kept.
- R7: A qualifying dependent edge seen while waiting for a reference edge, with no reference edge in the same sample, increments the dependent-miss counter. This happens only once at least one measurement has been closed since reset.
- R8: If a qualifying dependent edge and a qualifying reference edge fall on the same sample while a measurement is open, the delay is reported and a new measurement opens at that sample.
- R9: Each miss counter is CNT_W bits wide and wraps to 0 after its maximum. Its pulse is high for exactly the one cycle after the qualifying sample, and the count has its new value in that same cycle.
- R10: The tick count saturates at the largest DLY_W-bit value, so a longer delay is reported as that maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample strobe; both channels are sampled when high |
| ref_i | input | 1 | Reference clock channel sample |
| dep_i | input | 1 | Dependent signal channel sample |
| ref_mode_i | input | 2 | Reference edge selector (R2 codes) |
| dep_mode_i | input | 2 | Dependent edge selector (R2 codes) |
| delay_o | output | DLY_W | Last measured delay in sample ticks |
| delay_valid_o | output | 1 | One-cycle pulse marking a new delay |
| ref_miss_cnt_o | output | CNT_W | Reference-miss count |
| ref_miss_o | output | 1 | Pulse marking a reference-miss increment |
| dep_miss_cnt_o | output | CNT_W | Dependent-miss count |
| dep_miss_o | output | 1 | Pulse marking a dependent-miss increment |

## Verification
The bound checker holds on every cycle these rules: every pulse follows an enabled sample, each miss counter moves by exactly one with its pulse and otherwise stays still, a miss never shares its cycle with a delay report, and the delay output only changes with its valid pulse. Some behaviour depends on the history of the inputs: the delay value itself, zero delay on coincident edges, a new measurement opening on a closing sample, the rule that dependent misses count only after the first closed measurement, the edge selector codes, saturation and wrap. Only the bench scenarios can show these, by comparing against a reference model. A second instance with narrow counters is used to reach wrap and saturation.

// File: rtl/edly_pkg.sv
package edly_pkg;
  typedef enum logic {
    ST_WAIT_REF = 1'b0,
    ST_WAIT_DEP = 1'b1
  } meas_st_e;

  localparam logic [1:0] MODE_RISE = 2'b00;
  localparam logic [1:0] MODE_FALL = 2'b01;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/edly_edge_qual.sv
module edly_edge_qual
  import edly_pkg::*;
(
  input  logic       prev_i,
  input  logic       cur_i,
  input  logic [1:0] mode_i,
  output logic       hit_o
);
  always_comb begin
    unique case (mode_i)
      MODE_RISE: hit_o = ~prev_i & cur_i;
      MODE_FALL: hit_o = prev_i & ~cur_i;
      default:   hit_o = prev_i ^ cur_i;
    endcase
  end
endmodule

// File: rtl/edly_wrap_cnt.sv
module edly_wrap_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= inc_i;
      if (inc_i) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/edly_sat_tmr.sv
module edly_sat_tmr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W-1:0] val_q;

  assign nxt_o = (val_q == MAX_VAL) ? MAX_VAL : val_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (clr_i)  val_q <= '0;
    else if (step_i) val_q <= nxt_o;
  end
endmodule

// File: rtl/edge_delay_meter.sv
module edge_delay_meter
  import edly_pkg::*;
#(
  parameter int unsigned DLY_W = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_en_i,
  input  logic             ref_i,
  input  logic             dep_i,
  input  logic [1:0]       ref_mode_i,
  input  logic [1:0]       dep_mode_i,
  output logic [DLY_W-1:0] delay_o,
  output logic             delay_valid_o,
  output logic [CNT_W-1:0] ref_miss_cnt_o,
  output logic             ref_miss_o,
  output logic [CNT_W-1:0] dep_miss_cnt_o,
  output logic             dep_miss_o
);
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_DEP = 1;

  logic [NUM_CH-1:0] cur, prev_q, hit;
  logic [1:0]        mode [NUM_CH];

  assign cur[CH_REF]  = ref_i;
  assign cur[CH_DEP]  = dep_i;
  assign mode[CH_REF] = ref_mode_i;
  assign mode[CH_DEP] = dep_mode_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    edly_edge_qual u_qual (
      .prev_i (prev_q[c]),
      .cur_i  (cur[c]),
      .mode_i (mode[c]),
      .hit_o  (hit[c])
    );
  end

  meas_st_e         st_q, st_d;
  logic             seen_q, seen_d;
  logic             tmr_clr, tmr_step, fire;
  logic             ref_inc, dep_inc;
  logic [DLY_W-1:0] tmr_nxt, fire_val;

  edly_sat_tmr #(.W(DLY_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .step_i (tmr_step),
    .nxt_o  (tmr_nxt)
  );

  always_comb begin
    st_d     = st_q;
    seen_d   = seen_q;
    tmr_clr  = 1'b0;
    tmr_step = 1'b0;
    fire     = 1'b0;
    fire_val = '0;
    ref_inc  = 1'b0;
    dep_inc  = 1'b0;
    if (smp_en_i) begin
      unique case (st_q)
        ST_WAIT_REF: begin
          if (hit[CH_REF]) begin
            if (hit[CH_DEP]) begin
              // coincident edges: zero delay, stay armed for reference
              fire   = 1'b1;
              seen_d = 1'b1;
            end else begin
              st_d    = ST_WAIT_DEP;
              tmr_clr = 1'b1;
            end
          end else if (hit[CH_DEP] && seen_q) begin
            dep_inc = 1'b1;
          end
        end
        ST_WAIT_DEP: begin
          if (hit[CH_DEP]) begin
            fire     = 1'b1;
            fire_val = tmr_nxt;
            seen_d   = 1'b1;
            // reference edge on the closing sample reopens at once
            if (hit[CH_REF]) tmr_clr = 1'b1;
            else             st_d    = ST_WAIT_REF;
          end else begin
            tmr_step = 1'b1;
            ref_inc  = hit[CH_REF];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_WAIT_REF;
      seen_q        <= 1'b0;
      prev_q        <= '0;
      delay_o       <= '0;
      delay_valid_o <= 1'b0;
    end else begin
      st_q          <= st_d;
      seen_q        <= seen_d;
      delay_valid_o <= fire;
      if (smp_en_i) prev_q  <= cur;
      if (fire)     delay_o <= fire_val;
    end
  end

  edly_wrap_cnt #(.W(CNT_W)) u_ref_miss (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (ref_inc),
    .cnt_o   (ref_miss_cnt_o),
    .pulse_o (ref_miss_o)
  );

  edly_wrap_cnt #(.W(CNT_W)) u_dep_miss (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (dep_inc),
    .cnt_o   (dep_miss_cnt_o),
    .pulse_o (dep_miss_o)
  );
endmodule

// File: rtl/edly_chk.sv
module edly_chk #(
  parameter int unsigned DLY_W = 32,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_en_i,
  input logic [DLY_W-1:0] delay_o,
  input logic             delay_valid_o,
  input logic [CNT_W-1:0] ref_miss_cnt_o,
  input logic             ref_miss_o,
  input logic [CNT_W-1:0] dep_miss_cnt_o,
  input logic             dep_miss_o
);
  a_r3_valid_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_valid_o |-> $past(smp_en_i));

  a_r3_miss_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_miss_o || dep_miss_o) |-> $past(smp_en_i));

  a_r9_ref_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_miss_o |-> ref_miss_cnt_o == CNT_W'($past(ref_miss_cnt_o) + 1'b1));

  a_r9_ref_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_miss_o |-> $stable(ref_miss_cnt_o));

  a_r9_dep_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dep_miss_o |-> dep_miss_cnt_o == CNT_W'($past(dep_miss_cnt_o) + 1'b1));

  a_r9_dep_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dep_miss_o |-> $stable(dep_miss_cnt_o));

  a_r6_ref_miss_no_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_miss_o |-> !delay_valid_o);

  a_r7_dep_miss_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dep_miss_o |-> !delay_valid_o && !ref_miss_o);

  a_r4_delay_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !delay_valid_o |-> $stable(delay_o));
endmodule

bind edge_delay_meter edly_chk #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .smp_en_i       (smp_en_i),
  .delay_o        (delay_o),
  .delay_valid_o  (delay_valid_o),
  .ref_miss_cnt_o (ref_miss_cnt_o),
  .ref_miss_o     (ref_miss_o),
  .dep_miss_cnt_o (dep_miss_cnt_o),
  .dep_miss_o     (dep_miss_o)
);

// File: tb/tb_edge_delay_meter.sv
module tb_edge_delay_meter;
  localparam int CLK_P = 10;
  localparam int NW    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, r = 1'b0, d = 1'b0;
  logic [1:0] rm = 2'b00, dm = 2'b00;

  logic [31:0] dly;   logic dvld, cmp, smp; logic [15:0] cmc, smc;
  logic [NW-1:0] n_dly; logic n_dvld, n_cmp, n_smp; logic [NW-1:0] n_cmc, n_smc;

  always #(CLK_P/2) clk = ~clk;

  edge_delay_meter dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_en_i(en), .ref_i(r), .dep_i(d),
    .ref_mode_i(rm), .dep_mode_i(dm), .delay_o(dly), .delay_valid_o(dvld),
    .ref_miss_cnt_o(cmc), .ref_miss_o(cmp), .dep_miss_cnt_o(smc), .dep_miss_o(smp));

  edge_delay_meter #(.DLY_W(NW), .CNT_W(NW)) dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .smp_en_i(en), .ref_i(r), .dep_i(d),
    .ref_mode_i(rm), .dep_mode_i(dm), .delay_o(n_dly), .delay_valid_o(n_dvld),
    .ref_miss_cnt_o(n_cmc), .ref_miss_o(n_cmp), .dep_miss_cnt_o(n_smc), .dep_miss_o(n_smp));

  typedef struct {
    bit vld; int dly; bit cp; int cc; bit sp; int sc; string req;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  logic [1:0] want_rm = 2'b00, want_dm = 2'b00;
  // reference model state
  bit m_wait_dep = 0, m_seen = 0, m_pr = 0, m_pd = 0;
  int m_cnt = 0, m_cm = 0, m_sm = 0;

  function automatic bit qual(bit p, bit c, bit [1:0] m);
    case (m)
      2'b00:   return !p && c;
      2'b01:   return p && !c;
      default: return p != c;
    endcase
  endfunction

  task automatic smp_step(bit e, bit rv, bit dv, string req);
    exp_t x;
    bit re, de;
    @(negedge clk);
    en = e; r = rv; d = dv; rm = want_rm; dm = want_dm;
    x = '{vld: 0, dly: 0, cp: 0, cc: 0, sp: 0, sc: 0, req: req};
    if (e) begin
      re = qual(m_pr, rv, want_rm);
      de = qual(m_pd, dv, want_dm);
      if (!m_wait_dep) begin
        if (re && de) begin x.vld = 1; x.dly = 0; m_seen = 1; end
        else if (re) begin m_wait_dep = 1; m_cnt = 0; end
        else if (de && m_seen) begin x.sp = 1; m_sm++; end
      end else begin
        if (de) begin
          x.vld = 1; x.dly = m_cnt + 1; m_seen = 1;
          if (re) m_cnt = 0; else m_wait_dep = 0;
        end else begin
          m_cnt++;
          if (re) begin x.cp = 1; m_cm++; end
        end
      end
      m_pr = rv; m_pd = dv;
    end
    x.cc = m_cm; x.sc = m_sm;
    q.push_back(x);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t x;
    int nd;
    bit ok;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        x = q.pop_front();
        nd = (x.dly > 7) ? 7 : x.dly;
        ok = (dvld == x.vld) && (!x.vld || dly == 32'(x.dly)) &&
             (cmp == x.cp) && (int'(cmc) == (x.cc & 16'hFFFF)) &&
             (smp == x.sp) && (int'(smc) == (x.sc & 16'hFFFF)) &&
             (n_dvld == x.vld) && (!x.vld || int'(n_dly) == nd) &&
             (n_cmp == x.cp) && (int'(n_cmc) == (x.cc & 7)) &&
             (n_smp == x.sp) && (int'(n_smc) == (x.sc & 7));
        n_chk++;
        if (!ok) begin
          n_bad++;
          $display("FAIL %s: act vld=%0b dly=%0d cp=%0b cc=%0d sp=%0b sc=%0d nd=%0d ncc=%0d nsc=%0d exp vld=%0b dly=%0d cp=%0b cc=%0d sp=%0b sc=%0d nd=%0d",
                   x.req, dvld, dly, cmp, cmc, smp, smc, n_dly, n_cmc, n_smc,
                   x.vld, x.dly, x.cp, x.cc, x.sp, x.sc, nd);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: act running exp finished");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    n_chk++;
    if (dly !== 0 || dvld !== 0 || cmc !== 0 || cmp !== 0 || smc !== 0 || smp !== 0) begin
      n_bad++;
      $display("FAIL R1: act dly=%0d vld=%0b cc=%0d sc=%0d exp all 0", dly, dvld, cmc, smc);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1/R7: dependent edge before any closed measurement is not a miss
    smp_step(1, 0, 0, "R1");
    smp_step(1, 0, 1, "R7");
    smp_step(1, 0, 0, "R7");
    // R4: basic delay of 3
    smp_step(1, 1, 0, "R4");
    smp_step(1, 1, 0, "R4");
    smp_step(1, 1, 0, "R4");
    smp_step(1, 1, 1, "R4");
    // R7: dependent miss after first closed measurement
    smp_step(1, 1, 0, "R7");
    smp_step(1, 1, 1, "R7");
    // R3: disabled samples ignored
    smp_step(0, 0, 0, "R3");
    smp_step(0, 1, 1, "R3");
    smp_step(1, 1, 1, "R3");
    smp_step(1, 0, 0, "R3");
    smp_step(1, 1, 0, "R3");
    for (int i = 0; i < 3; i++) smp_step(0, 1, 0, "R3");
    smp_step(1, 1, 1, "R3");
    // R5: coincident edges
    smp_step(1, 0, 0, "R5");
    smp_step(1, 1, 1, "R5");
    smp_step(1, 1, 1, "R5");
    // R6: reference miss keeps start
    smp_step(1, 0, 0, "R6");
    smp_step(1, 1, 0, "R6");
    smp_step(1, 0, 0, "R6");
    smp_step(1, 1, 0, "R6");
    smp_step(1, 1, 1, "R6");
    // R8: close and reopen on one sample
    smp_step(1, 0, 0, "R8");
    smp_step(1, 1, 0, "R8");
    smp_step(1, 0, 0, "R8");
    smp_step(1, 1, 1, "R8");
    smp_step(1, 1, 0, "R8");
    smp_step(1, 1, 1, "R8");
    // R2: falling, any, code 2'b11
    want_rm = 2'b01; want_dm = 2'b01;
    smp_step(1, 0, 1, "R2");
    smp_step(1, 0, 0, "R2");
    want_rm = 2'b10; want_dm = 2'b10;
    smp_step(1, 1, 0, "R2");
    smp_step(1, 1, 1, "R2");
    want_rm = 2'b11; want_dm = 2'b11;
    smp_step(1, 0, 1, "R2");
    smp_step(1, 0, 0, "R2");
    want_rm = 2'b00; want_dm = 2'b00;
    smp_step(1, 1, 1, "R2");
    smp_step(1, 0, 0, "R2");
    // R9: wrap of both miss counters in the narrow instance
    smp_step(1, 1, 0, "R9");
    for (int i = 0; i < 9; i++) begin
      smp_step(1, 0, 0, "R9");
      smp_step(1, 1, 0, "R9");
    end
    smp_step(1, 1, 1, "R9");
    for (int i = 0; i < 9; i++) begin
      smp_step(1, 1, 0, "R9");
      smp_step(1, 1, 1, "R9");
    end
    // R10: saturation in the narrow instance
    smp_step(1, 0, 0, "R10");
    smp_step(1, 1, 0, "R10");
    for (int i = 0; i < 12; i++) smp_step(1, 1, 0, "R10");
    smp_step(1, 1, 1, "R10");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) begin
        want_rm = 2'($urandom_range(0, 3));
        want_dm = 2'($urandom_range(0, 3));
      end
      smp_step(($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom), "R4");
    end
    smp_step(0, 0, 0, "R3");
    smp_step(0, 0, 0, "R3");
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R4: act %0d pending exp 0 pending", q.size());
    end
    report();
  end
endmodule